// File: doc/BRIEF.md
# Substrate Temperature Limit and Slew Monitor

This block sits behind a digital temperature front end and inspects every sample it is handed. A sample is a 12-bit signed value at 1/16 °C per LSB, marked by a one-cycle valid strobe. The block raises a tamper indication when a reading leaves a programmed band, either above its ceiling or below its floor. It also raises one when the temperature moves too quickly in either direction. That second check catches attacks that chill the die to stretch memory retention.

The rate is measured over a programmable window of 1 to 8 valid samples. It is the difference between the newest reading and the reading taken that many valid samples earlier, compared against an unsigned slew threshold. Each of the four causes latches into its own sticky flag, and the flags are ORed into one tamper output. A flag can be cleared only by a clear strobe, and only once its cause has gone away. The limits, the slew threshold and the window are set through a small parallel write port. No enable bit exists, so monitoring cannot be turned off.

Top module: `thermal_guard`

## Requirements
- R1: A valid sample strictly greater than the ceiling sets `flag_high` at the clock edge that captures it; a sample equal to the ceiling does not.
- R2: A valid sample strictly less than the floor sets `flag_low` at the capturing edge; a sample equal to the floor does not.
- R3: When the current sample minus the reference sample is strictly greater than the slew threshold, `flag_rise` is set at the capturing edge.
- R4: When the reference sample minus the current sample is strictly greater than the slew threshold, `flag_fall` is set at the capturing edge.
- R5: The reference sample is the one captured W valid samples before the current one, where W is the window setting. No rate check is made for a sample until at least W valid samples have been stored since reset.
- R6: Writes with `cfg_we` high go to the register selected by `cfg_addr`: 0 = ceiling (signed), 1 = floor (signed), 2 = slew threshold (unsigned), 3 = window. A window write of 0 becomes 1, and one above 8 becomes 8. After reset the values are ceiling 2047, floor -2048, slew 4095 and window 1.
- R7: Each flag is sticky. A `flag_clr` pulse clears a flag only if the most recent valid sample did not show that cause. If a valid sample shows the cause in the same cycle as the clear, the flag is set.
- R8: `tamper` is high whenever any of the four flags is high, and no input can suppress monitoring.
- R9: After reset all four flags and `tamper` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | One-cycle strobe marking a new sample |
| smp_data | input | 12 | Signed temperature sample, 1/16 °C per LSB |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 2 | Register select (0 ceiling, 1 floor, 2 slew, 3 window) |
| cfg_wdata | input | 12 | Register write data |
| flag_clr | input | 1 | Clear request for flags whose cause is gone |
| flag_high | output | 1 | Sticky over-ceiling flag |
| flag_low | output | 1 | Sticky under-floor flag |
| flag_rise | output | 1 | Sticky fast-rise flag |
| flag_fall | output | 1 | Sticky fast-fall flag |
| tamper | output | 1 | OR of all four flags |

## Verification
The assertions assume that `smp_valid` is a clean synchronous strobe and that `cfg_addr` and `cfg_wdata` are stable while `cfg_we` is high. They also assume a flag only falls in the cycle after a clear whose cause was already absent. The bench drives each input at the falling edge, so every strobe stays one cycle wide. It keeps the generated samples inside the 12-bit signed range, and it sweeps every window setting, including the clamped values 0, 12 and 15. At each setting it drives a pseudo-random walk with occasional large jumps, so that both rate directions trip and also stay quiet exactly at the threshold.

// File: rtl/thermal_pkg.sv
package thermal_pkg;
  typedef enum logic [1:0] {
    REG_CEIL  = 2'd0,
    REG_FLOOR = 2'd1,
    REG_SLEW  = 2'd2,
    REG_WIN   = 2'd3
  } cfg_reg_e;

  localparam int NCAUSE     = 4;
  localparam int CAUSE_HIGH = 0;
  localparam int CAUSE_LOW  = 1;
  localparam int CAUSE_RISE = 2;
  localparam int CAUSE_FALL = 3;
endpackage

// File: rtl/thermal_cfg.sv
module thermal_cfg
  import thermal_pkg::*;
#(
  parameter int SMP_W   = 12,
  parameter int MAX_WIN = 8,
  localparam int WIN_W  = $clog2(MAX_WIN + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_we,
  input  logic [1:0]              cfg_addr,
  input  logic [SMP_W-1:0]        cfg_wdata,
  output logic signed [SMP_W-1:0] ceil_lim,
  output logic signed [SMP_W-1:0] floor_lim,
  output logic [SMP_W-1:0]        slew_lim,
  output logic [WIN_W-1:0]        win_len
);
  localparam logic [SMP_W-1:0] CEIL_RST  = {1'b0, {(SMP_W-1){1'b1}}};
  localparam logic [SMP_W-1:0] FLOOR_RST = {1'b1, {(SMP_W-1){1'b0}}};
  localparam logic [SMP_W-1:0] SLEW_RST  = {SMP_W{1'b1}};

  logic [SMP_W-1:0] ceil_q, ceil_d, floor_q, floor_d, slew_q, slew_d;
  logic [WIN_W-1:0] win_q, win_d, win_wr;

  always_comb begin
    if (cfg_wdata == '0)
      win_wr = WIN_W'(1);
    else if (cfg_wdata > SMP_W'(MAX_WIN))
      win_wr = WIN_W'(MAX_WIN);
    else
      win_wr = cfg_wdata[WIN_W-1:0];
  end

  always_comb begin
    ceil_d  = ceil_q;
    floor_d = floor_q;
    slew_d  = slew_q;
    win_d   = win_q;
    if (cfg_we) begin
      case (cfg_reg_e'(cfg_addr))
        REG_CEIL:  ceil_d  = cfg_wdata;
        REG_FLOOR: floor_d = cfg_wdata;
        REG_SLEW:  slew_d  = cfg_wdata;
        REG_WIN:   win_d   = win_wr;
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ceil_q  <= CEIL_RST;
      floor_q <= FLOOR_RST;
      slew_q  <= SLEW_RST;
      win_q   <= WIN_W'(1);
    end else begin
      ceil_q  <= ceil_d;
      floor_q <= floor_d;
      slew_q  <= slew_d;
      win_q   <= win_d;
    end
  end

  assign ceil_lim  = $signed(ceil_q);
  assign floor_lim = $signed(floor_q);
  assign slew_lim  = slew_q;
  assign win_len   = win_q;

  // R6
  win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_q >= WIN_W'(1)) && (win_q <= WIN_W'(MAX_WIN)));
endmodule

// File: rtl/thermal_hist.sv
module thermal_hist #(
  parameter int SMP_W   = 12,
  parameter int MAX_WIN = 8,
  localparam int WIN_W  = $clog2(MAX_WIN + 1),
  localparam int IDX_W  = $clog2(MAX_WIN)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  input  logic signed [SMP_W-1:0] smp_data,
  input  logic [WIN_W-1:0]        win_len,
  output logic signed [SMP_W-1:0] ref_smp,
  output logic                    ref_ok
);
  logic signed [SMP_W-1:0] hist_q [MAX_WIN];
  logic signed [SMP_W-1:0] hist_d [MAX_WIN];
  logic [WIN_W-1:0]        fill_q, fill_d;
  logic [IDX_W-1:0]        sel;

  for (genvar g = 0; g < MAX_WIN; g++) begin : g_stage
    if (g == 0) begin : g_head
      assign hist_d[g] = smp_valid ? smp_data : hist_q[g];
    end else begin : g_body
      assign hist_d[g] = smp_valid ? hist_q[g-1] : hist_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q[g] <= '0;
      else        hist_q[g] <= hist_d[g];
    end
  end

  always_comb begin
    fill_d = fill_q;
    if (smp_valid && (fill_q < WIN_W'(MAX_WIN)))
      fill_d = fill_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_q <= '0;
    else        fill_q <= fill_d;
  end

  assign sel     = IDX_W'(win_len - 1'b1);
  assign ref_smp = hist_q[sel];
  assign ref_ok  = (fill_q >= win_len);

  // R5
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= WIN_W'(MAX_WIN));
  // R5
  fill_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_valid |=> $stable(fill_q));
endmodule

// File: rtl/thermal_eval.sv
module thermal_eval
  import thermal_pkg::*;
#(
  parameter int SMP_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_valid,
  input  logic signed [SMP_W-1:0] smp_data,
  input  logic signed [SMP_W-1:0] ceil_lim,
  input  logic signed [SMP_W-1:0] floor_lim,
  input  logic [SMP_W-1:0]        slew_lim,
  input  logic signed [SMP_W-1:0] ref_smp,
  input  logic                    ref_ok,
  input  logic                    flag_clr,
  output logic [NCAUSE-1:0]       flags,
  output logic                    tamper
);
  localparam int DW = SMP_W + 2;

  logic signed [DW-1:0] cur_x, ref_x, up_x, dn_x, lim_x;
  logic [NCAUSE-1:0]    cause, live_q, live_d, flag_q, flag_d;

  assign cur_x = DW'(smp_data);
  assign ref_x = DW'(ref_smp);
  assign up_x  = cur_x - ref_x;
  assign dn_x  = ref_x - cur_x;
  assign lim_x = $signed({2'b00, slew_lim});

  always_comb begin
    cause             = '0;
    cause[CAUSE_HIGH] = smp_data > ceil_lim;
    cause[CAUSE_LOW]  = smp_data < floor_lim;
    cause[CAUSE_RISE] = ref_ok && (up_x > lim_x);
    cause[CAUSE_FALL] = ref_ok && (dn_x > lim_x);
  end

  always_comb begin
    for (int i = 0; i < NCAUSE; i++) begin
      flag_d[i] = flag_q[i];
      live_d[i] = live_q[i];
      if (smp_valid) live_d[i] = cause[i];
      if (smp_valid && cause[i])
        flag_d[i] = 1'b1;
      else if (flag_clr && !live_q[i])
        flag_d[i] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      live_q <= '0;
    end else begin
      flag_q <= flag_d;
      live_q <= live_d;
    end
  end

  assign flags  = flag_q;
  assign tamper = |flag_q;

  for (genvar c = 0; c < NCAUSE; c++) begin : g_chk
    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flag_q[c]) |-> ($past(flag_clr) && !$past(live_q[c])));
  end

  // R1
  high_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (smp_data > ceil_lim)) |=> flag_q[CAUSE_HIGH]);
  // R2
  low_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && (smp_data < floor_lim)) |=> flag_q[CAUSE_LOW]);
  // R3
  slew_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !($rose(flag_q[CAUSE_RISE]) && $rose(flag_q[CAUSE_FALL])));
  // R5
  rate_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ref_ok) |=> !$rose(flag_q[CAUSE_RISE]) && !$rose(flag_q[CAUSE_FALL]));
endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
  import thermal_pkg::*;
#(
  parameter int SMP_W   = 12,
  parameter int MAX_WIN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] smp_data,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [SMP_W-1:0] cfg_wdata,
  input  logic             flag_clr,
  output logic             flag_high,
  output logic             flag_low,
  output logic             flag_rise,
  output logic             flag_fall,
  output logic             tamper
);
  localparam int WIN_W = $clog2(MAX_WIN + 1);

  logic signed [SMP_W-1:0] ceil_lim, floor_lim, ref_smp, smp_s;
  logic [SMP_W-1:0]        slew_lim;
  logic [WIN_W-1:0]        win_len;
  logic                    ref_ok;
  logic [NCAUSE-1:0]       flags;

  assign smp_s = $signed(smp_data);

  thermal_cfg #(.SMP_W(SMP_W), .MAX_WIN(MAX_WIN)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ceil_lim(ceil_lim), .floor_lim(floor_lim),
    .slew_lim(slew_lim), .win_len(win_len)
  );

  thermal_hist #(.SMP_W(SMP_W), .MAX_WIN(MAX_WIN)) u_hist (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_s),
    .win_len(win_len), .ref_smp(ref_smp), .ref_ok(ref_ok)
  );

  thermal_eval #(.SMP_W(SMP_W)) u_eval (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_s),
    .ceil_lim(ceil_lim), .floor_lim(floor_lim), .slew_lim(slew_lim),
    .ref_smp(ref_smp), .ref_ok(ref_ok), .flag_clr(flag_clr),
    .flags(flags), .tamper(tamper)
  );

  assign flag_high = flags[CAUSE_HIGH];
  assign flag_low  = flags[CAUSE_LOW];
  assign flag_rise = flags[CAUSE_RISE];
  assign flag_fall = flags[CAUSE_FALL];
endmodule

// File: tb/thermal_guard_tb.sv
module thermal_guard_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, smp_valid, cfg_we, flag_clr;
  logic [11:0] smp_data, cfg_wdata;
  logic [1:0]  cfg_addr;
  logic        flag_high, flag_low, flag_rise, flag_fall, tamper;

  thermal_guard u_dut (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .flag_clr(flag_clr), .flag_high(flag_high), .flag_low(flag_low),
    .flag_rise(flag_rise), .flag_fall(flag_fall), .tamper(tamper)
  );

  int errs = 0, chks = 0;
  int m_ceil, m_floor, m_slew, m_win;
  int mh[$];
  bit mf[4], ml[4];
  bit done = 0;

  task automatic check(string req);
    logic [4:0] act, exp;
    act = {tamper, flag_fall, flag_rise, flag_low, flag_high};
    exp = {mf[0] | mf[1] | mf[2] | mf[3], mf[3], mf[2], mf[1], mf[0]};
    chks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: {tamper,fall,rise,low,high} actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; smp_valid = 0; cfg_we = 0; flag_clr = 0;
    smp_data = '0; cfg_addr = '0; cfg_wdata = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    mh.delete();
    for (int i = 0; i < 4; i++) begin mf[i] = 0; ml[i] = 0; end
    m_ceil = 2047; m_floor = -2048; m_slew = 4095; m_win = 1;
    @(negedge clk);
    check("R9 reset state");
  endtask

  task automatic wr(int addr, int val);
    cfg_we = 1'b1; cfg_addr = 2'(addr); cfg_wdata = 12'(val);
    @(negedge clk);
    cfg_we = 1'b0;
    case (addr)
      0: m_ceil  = val;
      1: m_floor = val;
      2: m_slew  = val & 12'hfff;
      default: m_win = (val == 0) ? 1 : (val > 8 ? 8 : val);
    endcase
  endtask

  // one cycle: optional sample, optional clear, then compare
  task automatic step(int v, bit vld, bit clr, string req);
    bit c[4];
    int d;
    for (int i = 0; i < 4; i++) c[i] = 0;
    if (vld) begin
      c[0] = v > m_ceil;
      c[1] = v < m_floor;
      if (mh.size() >= m_win) begin
        d = v - mh[m_win-1];
        c[2] = d > m_slew;
        c[3] = -d > m_slew;
      end
    end
    for (int i = 0; i < 4; i++) begin
      if (vld && c[i]) mf[i] = 1;
      else if (clr && !ml[i]) mf[i] = 0;
    end
    if (vld) begin
      for (int i = 0; i < 4; i++) ml[i] = c[i];
      mh.push_front(v);
      if (mh.size() > 8) void'(mh.pop_back());
    end
    smp_valid = vld; smp_data = 12'(v); flag_clr = clr;
    @(negedge clk);
    smp_valid = 0; flag_clr = 0;
    check(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++; chks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
    end
  end

  initial begin
    int raws[11] = '{0, 1, 2, 3, 4, 5, 6, 7, 8, 12, 15};
    int unsigned seed;
    int v, dl;
    do_reset();
    // R6 defaults: full-scale extremes and full-scale swing trip nothing
    step(2047, 1, 0, "R6 default ceiling");
    step(-2048, 1, 0, "R6 default floor/slew");
    step(2047, 1, 0, "R6 default slew");
    // R1 / R2 boundaries
    wr(0, 400); wr(1, -160);
    step(400, 1, 0, "R1 equal ceiling");
    step(401, 1, 0, "R1 above ceiling");
    step(-160, 1, 0, "R2 equal floor");
    step(-161, 1, 0, "R2 below floor");
    // R7 clear while low cause live: high clears, low stays
    step(0, 0, 1, "R7 clear partial");
    step(0, 1, 0, "R7 quiet sample");
    step(0, 0, 1, "R7 clear after cause gone");
    step(401, 1, 1, "R7 set wins over clear");
    step(0, 0, 1, "R7 clear blocked live");
    // R3 / R4 boundaries with window 1
    wr(2, 20); wr(3, 1);
    step(0, 1, 0, "R3 base");
    step(20, 1, 0, "R3 equal slew");
    step(0, 1, 1, "R4 equal slew");
    step(41, 1, 0, "R3 rise over");
    step(20, 1, 0, "R4 fall over");
    step(20, 1, 1, "R8 clear all");
    // R5 window sweep including clamped settings
    seed = 32'h1357_9bdf;
    foreach (raws[k]) begin
      do_reset();
      wr(0, 600); wr(1, -300); wr(2, 30); wr(3, raws[k]);
      v = 100;
      for (int n = 0; n < 60; n++) begin
        seed = seed * 1103515245 + 12345;
        dl = int'((seed >> 16) % 41) - 20;
        if (((seed >> 8) % 13) == 0) dl = dl * 6;
        v = v + dl;
        if (v > 2047) v = 2047;
        if (v < -2048) v = -2048;
        step(v, ((seed >> 4) % 5) != 0, (n % 7) == 6, "R5 window sweep R1 R2 R3 R4");
      end
      // R5 window change mid-stream
      wr(3, 3);
      for (int n = 0; n < 10; n++) step(v + 12 * n, 1, n == 9, "R5 window change");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule